// File: doc/BRIEF.md
# Voltage Sensor Sequencer Controller

This block drives an eight-channel voltage converter from a single 32-bit command register. Software writes the register with a sequence selection, a conversion mode, a single-channel choice, two polarity selects and a calibration flag, then sets the run bit. The controller steps through the chosen channel list. For each channel it raises a request carrying that channel number to the converter and waits for the converter's done pulse.

Each finished conversion leaves the block as one stream beat. A beat carries the channel tag and the 6-bit sample. Start-of-packet and end-of-packet flags mark where each pass over the list begins and ends. In one-round mode the block makes a single pass and then drops the run bit by itself. In continuous mode it goes back to the start of the list until software writes the run bit to zero. After that write, the conversion already under way is completed and delivered before the block halts.

Top module: `vsense_seq_ctrl`

## Requirements
- R1: The command word at address 0 holds run at bit 0, mode at bits 2:1, channel select at bits 6:4, sequence select at bits 9:8, the polarity selects at bits 11:10 and calibration at bit 12. All fields reset to 0. Reserved bits and any other address read as 0.
- R2: The sequence select gives the channel list. 2'b00 is channels 2,3,4,5,6,7 in that order. 2'b01 is channels 0 to 7 in ascending order. 2'b10 is channels 0 then 1. 2'b11 is only the channel held in the channel-select field.
- R3: A mode value other than 2'b01 is one-round. Setting run converts the list exactly once. Run reads 0 in the cycle the final beat is valid, and no further requests follow.
- R4: Mode 2'b01 is continuous. After the last channel of the list, the list starts again at its first channel. With sequence 2'b11 the single channel is converted over and over.
- R5: Writing run=0 while running lets the conversion under way finish and deliver its beat. Run then reads 0 and cv_req stays low.
- R6: Every cv_done pulse that answers a request produces exactly one beat, one clock later. The beat is valid for a single cycle, carries the requested channel on st_chan, and carries cv_result on st_data.
- R7: st_sop is set on the beat for the first list position and st_eop on the beat for the last list position. With sequence 2'b11 both flags are set on every beat.
- R8: While run is set, a write changes no field except that run=0 requests a stop. Writing run=1 again has no effect.
- R9: cv_req stays high with a stable cv_chan until cv_done. It is low for at least one cycle between two conversions.
- R10: cv_unipolar mirrors bits 11:10 of the command word and cv_cal mirrors bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | ADDR_W | Word address of the register access |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, combinational from csr_addr |
| cv_req | output | 1 | Conversion request to the converter |
| cv_chan | output | 3 | Channel number to convert |
| cv_unipolar | output | 2 | Polarity selects for channels 0 and 1 |
| cv_cal | output | 1 | Calibrated-output selection |
| cv_done | input | 1 | Converter done pulse |
| cv_result | input | 6 | Converter sample, valid with cv_done |
| st_valid | output | 1 | Stream beat valid |
| st_chan | output | 3 | Channel tag of the beat |
| st_data | output | 6 | Sample of the beat |
| st_sop | output | 1 | First list position of the pass |
| st_eop | output | 1 | Last list position of the pass |

## Verification
The bench covers every sequence selection in one-round mode at two converter latencies. For each beat it derives the channel, flags and data arithmetically. A wrong list table, a missing end-of-packet flag or a run bit that never clears shows up as a sequence mismatch or a timeout. Stop requests in continuous mode check that the wrap goes back to the list's first channel and that at most one beat follows the stop write; a design that aborted the conversion in progress, or kept requesting, fails here. A reconfiguring write in the middle of a run checks that the stored fields and the converter-side outputs stay frozen. Reserved-bit masking and the treatment of unused mode codes as one-round are also checked.

// File: rtl/vsq_pkg.sv
package vsq_pkg;
  localparam int CH_W  = 3;
  localparam int DAT_W = 6;
  localparam int LEN_W = CH_W + 1;

  typedef struct packed {
    logic            cal;
    logic [1:0]      bu;
    logic [1:0]      md;
    logic [CH_W-1:0] chsel;
    logic [1:0]      mode;
    logic            run;
  } vsq_cmd_t;

  // number of list positions for a sequence selection
  function automatic logic [LEN_W-1:0] seq_len(input logic [1:0] md);
    case (md)
      2'b00:   seq_len = LEN_W'(6);
      2'b01:   seq_len = LEN_W'(8);
      2'b10:   seq_len = LEN_W'(2);
      default: seq_len = LEN_W'(1);
    endcase
  endfunction

  // channel visited at list position idx
  function automatic logic [CH_W-1:0] seq_chan(input logic [1:0] md,
                                               input logic [CH_W-1:0] chsel,
                                               input logic [CH_W-1:0] idx);
    case (md)
      2'b00:   seq_chan = idx + CH_W'(2);
      2'b11:   seq_chan = chsel;
      default: seq_chan = idx;
    endcase
  endfunction

  function automatic logic [31:0] pack_cmd(input vsq_cmd_t c);
    pack_cmd = {19'd0, c.cal, c.bu, c.md, 1'b0, c.chsel, 1'b0, c.mode, c.run};
  endfunction

  function automatic vsq_cmd_t unpack_cmd(input logic [31:0] w);
    vsq_cmd_t c;
    c.run   = w[0];
    c.mode  = w[2:1];
    c.chsel = w[6:4];
    c.md    = w[9:8];
    c.bu    = w[11:10];
    c.cal   = w[12];
    unpack_cmd = c;
  endfunction
endpackage

// File: rtl/vsq_cmd_reg.sv
module vsq_cmd_reg
  import vsq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [31:0] wdata,
  input  logic        finish,
  output vsq_cmd_t    cmd,
  output logic        stop_req
);
  logic [9:0] cfg_bits;
  assign cfg_bits = cmd[10:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd      <= '0;
      stop_req <= 1'b0;
    end else if (finish) begin
      cmd.run  <= 1'b0;
      stop_req <= 1'b0;
    end else if (wr_hit) begin
      if (!cmd.run)
        cmd <= unpack_cmd(wdata);
      else if (!wdata[0])
        stop_req <= 1'b1;
    end
  end

  // R8: configuration cannot move under a running sequence
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd.run) && cmd.run) |-> $stable(cfg_bits));

  // R5: a stop request only exists while running
  a_r5_stop_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> cmd.run);
endmodule

// File: rtl/vsq_walker.sv
module vsq_walker
  import vsq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  vsq_cmd_t        cmd,
  input  logic            stop_req,
  input  logic            cv_done,
  output logic            cv_req,
  output logic [CH_W-1:0] cv_chan,
  output logic            beat_fire,
  output logic            beat_sop,
  output logic            beat_eop,
  output logic            finish
);
  typedef enum logic [1:0] {W_IDLE, W_REQ, W_GAP} wstate_t;
  wstate_t         state;
  logic [CH_W-1:0] idx;
  logic            at_last;
  logic            cont;

  assign cont      = (cmd.mode == 2'b01);
  assign at_last   = ({1'b0, idx} == seq_len(cmd.md) - LEN_W'(1));
  assign cv_req    = (state == W_REQ);
  assign cv_chan   = seq_chan(cmd.md, cmd.chsel, idx);
  assign beat_fire = cv_req && cv_done;
  assign beat_sop  = (idx == '0);
  assign beat_eop  = at_last;

  always_comb begin
    finish = 1'b0;
    case (state)
      W_IDLE:  finish = cmd.run && stop_req;
      W_REQ:   finish = cv_done && (stop_req || (at_last && !cont));
      W_GAP:   finish = stop_req;
      default: finish = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= W_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        W_IDLE: if (cmd.run && !stop_req) begin
          state <= W_REQ;
          idx   <= '0;
        end
        W_REQ: if (cv_done) begin
          state <= finish ? W_IDLE : W_GAP;
          idx   <= at_last ? '0 : idx + CH_W'(1);
        end
        W_GAP: state <= stop_req ? W_IDLE : W_REQ;
        default: state <= W_IDLE;
      endcase
    end
  end

  // R9: request held with steady channel until answered
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_req && !cv_done) |=> (cv_req && $stable(cv_chan)));

  // R9: request drops after every answer
  a_r9_gap_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |=> !cv_req);
endmodule

// File: rtl/vsq_beat_out.sv
module vsq_beat_out
  import vsq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [CH_W-1:0]  chan,
  input  logic [DAT_W-1:0] data,
  input  logic             sop,
  input  logic             eop,
  output logic             st_valid,
  output logic [CH_W-1:0]  st_chan,
  output logic [DAT_W-1:0] st_data,
  output logic             st_sop,
  output logic             st_eop
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_chan  <= '0;
      st_data  <= '0;
      st_sop   <= 1'b0;
      st_eop   <= 1'b0;
    end else begin
      st_valid <= fire;
      if (fire) begin
        st_chan <= chan;
        st_data <= data;
        st_sop  <= sop;
        st_eop  <= eop;
      end
    end
  end

  // R6: beats never run back to back
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !st_valid);
endmodule

// File: rtl/vsense_seq_ctrl.sv
module vsense_seq_ctrl
  import vsq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_wr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              cv_req,
  output logic [CH_W-1:0]   cv_chan,
  output logic [1:0]        cv_unipolar,
  output logic              cv_cal,
  input  logic              cv_done,
  input  logic [DAT_W-1:0]  cv_result,
  output logic              st_valid,
  output logic [CH_W-1:0]   st_chan,
  output logic [DAT_W-1:0]  st_data,
  output logic              st_sop,
  output logic              st_eop
);
  vsq_cmd_t cmd;
  logic     stop_req;
  logic     finish;
  logic     beat_fire;
  logic     beat_sop;
  logic     beat_eop;
  logic     addr_hit;

  assign addr_hit    = (csr_addr == '0);
  assign csr_rdata   = addr_hit ? pack_cmd(cmd) : 32'd0;
  assign cv_unipolar = cmd.bu;
  assign cv_cal      = cmd.cal;

  vsq_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_hit(csr_wr && addr_hit), .wdata(csr_wdata),
    .finish(finish), .cmd(cmd), .stop_req(stop_req)
  );

  vsq_walker u_walk (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .stop_req(stop_req), .cv_done(cv_done),
    .cv_req(cv_req), .cv_chan(cv_chan), .beat_fire(beat_fire),
    .beat_sop(beat_sop), .beat_eop(beat_eop), .finish(finish)
  );

  vsq_beat_out u_out (
    .clk(clk), .rst_n(rst_n), .fire(beat_fire), .chan(cv_chan), .data(cv_result),
    .sop(beat_sop), .eop(beat_eop), .st_valid(st_valid), .st_chan(st_chan),
    .st_data(st_data), .st_sop(st_sop), .st_eop(st_eop)
  );

  // R3: one-round pass has dropped run by the time its tail beat shows
  a_r3_run_clear_at_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_eop && cmd.mode != 2'b01) |-> !cmd.run);

  // R7: a packet always opens on the list's first channel
  a_r7_sop_channel: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_sop) |-> (st_chan == seq_chan(cmd.md, cmd.chsel, '0)));

  // R6: a beat appears only after an answered request
  a_r6_valid_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> ($past(cv_done) && $past(cv_req)));
endmodule

// File: tb/vsense_seq_ctrl_test.sv
`timescale 1ns/100ps
module vsense_seq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  csr_addr = '0;
  logic        csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        cv_req;
  logic [2:0]  cv_chan;
  logic [1:0]  cv_unipolar;
  logic        cv_cal;
  logic        cv_done = 1'b0;
  logic [5:0]  cv_result = '0;
  logic        st_valid;
  logic [2:0]  st_chan;
  logic [5:0]  st_data;
  logic        st_sop;
  logic        st_eop;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  logic clr  = 1'b0;

  always #2.5 clk = ~clk;

  vsense_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .cv_req(cv_req),
    .cv_chan(cv_chan), .cv_unipolar(cv_unipolar), .cv_cal(cv_cal),
    .cv_done(cv_done), .cv_result(cv_result), .st_valid(st_valid),
    .st_chan(st_chan), .st_data(st_data), .st_sop(st_sop), .st_eop(st_eop)
  );

  // behavioural converter: result = {channel, conversion count mod 8}
  int cnt = 0;
  int nconv = 0;
  always @(posedge clk) begin
    cv_done <= 1'b0;
    if (clr) nconv <= 0;
    if (cv_req && !cv_done) begin
      if (cnt >= lat) begin
        cv_done   <= 1'b1;
        cv_result <= {cv_chan, 3'(nconv)};
        nconv     <= clr ? 1 : nconv + 1;
        cnt       <= 0;
      end else cnt <= cnt + 1;
    end
  end

  // beat recorder
  logic [2:0] b_chan [64];
  logic [5:0] b_data [64];
  logic       b_sop  [64];
  logic       b_eop  [64];
  logic       b_run  [64];
  int nb = 0;
  always @(negedge clk) begin
    if (clr) nb = 0;
    else if (st_valid) begin
      if (nb < 64) begin
        b_chan[nb] = st_chan; b_data[nb] = st_data;
        b_sop[nb] = st_sop; b_eop[nb] = st_eop; b_run[nb] = csr_rdata[0];
      end
      nb = nb + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int run, input int mode, input int chsel,
                                     input int md, input int bu, input int cal);
    return 32'((cal << 12) | (bu << 10) | (md << 8) | (chsel << 4) | (mode << 1) | run);
  endfunction

  function automatic int exp_len(input int md);
    return (md == 3) ? 1 : (md == 2) ? 2 : (md == 0) ? 6 : 8;
  endfunction

  function automatic int exp_ch(input int md, input int chsel, input int pos);
    if (md == 3) return chsel;
    return (md == 0) ? pos + 2 : pos;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
    @(posedge clk); #1;
    csr_wr = 1'b0; csr_addr = '0;
  endtask

  task automatic clear_rec();
    @(posedge clk); #1 clr = 1'b1;
    @(posedge clk); #1 clr = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int t;
    t = 0;
    @(negedge clk);
    while (csr_rdata[0] && t < 2000) begin @(negedge clk); t++; end
    chk(t < 2000, tag, t, 0);
  endtask

  // compare every recorded beat with the arithmetic pattern
  task automatic verify(input int md, input int chsel, input string tag);
    int len;
    len = exp_len(md);
    for (int j = 0; j < nb && j < 64; j++) begin
      int p, c;
      p = j % len;
      c = exp_ch(md, chsel, p);
      chk(b_chan[j] == 3'(c), {tag, " R2 chan"}, b_chan[j], c);
      chk(b_data[j] == 6'((c << 3) | (j & 7)), {tag, " R6 data"}, b_data[j], (c << 3) | (j & 7));
      chk(b_sop[j] == (p == 0) && b_eop[j] == (p == len - 1), {tag, " R7 flags"},
          {b_sop[j], b_eop[j]}, {p == 0, p == len - 1});
    end
  endtask

  task automatic one_round(input int md, input int chsel, input int mode, input int l);
    lat = l;
    clear_rec();
    wr(0, mk(1, mode, chsel, md, 0, 0));
    wait_idle("R3 run clear");
    repeat (30) @(negedge clk);
    chk(nb == exp_len(md), "R3 beat count", nb, exp_len(md));
    verify(md, chsel, "R3");
    if (nb > 0)
      chk(b_run[nb - 1] == 1'b0, "R3 run low on tail beat", b_run[nb - 1], 0);
    chk(cv_req == 1'b0, "R3 no request after pass", cv_req, 0);
  endtask

  task automatic cont_stop(input int md, input int chsel, input int want);
    int t, nbw;
    lat = 1;
    clear_rec();
    wr(0, mk(1, 1, chsel, md, 0, 0));
    t = 0;
    while (nb < want && t < 2000) begin @(negedge clk); t++; end
    wr(0, 32'd0);
    nbw = nb;
    wait_idle("R5 stop clears run");
    chk(nb >= want && nb - nbw <= 1, "R5 beats after stop", nb - nbw, 1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cv_req) begin chk(0, "R5 request after stop", 1, 0); break; end
    end
    chk(cv_req == 1'b0, "R5 idle converter", cv_req, 0);
    verify(md, chsel, "R4");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 50000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(csr_rdata == 32'd0, "R1 reset word", csr_rdata, 0);
    chk(!st_valid && !cv_req, "R1 reset outputs", {st_valid, cv_req}, 0);
    // R1 reserved masking, run left 0
    wr(0, 32'hFFFF_FFFE);
    @(negedge clk);
    chk(csr_rdata == 32'h0000_1F76, "R1 reserved read zero", csr_rdata, 32'h1F76);
    csr_addr = 4'd3;
    @(negedge clk);
    chk(csr_rdata == 32'd0, "R1 other address", csr_rdata, 0);
    csr_addr = 4'd0;
    // R10 mirrors
    wr(0, mk(0, 0, 0, 0, 2, 1));
    @(negedge clk);
    chk(cv_unipolar == 2'b10 && cv_cal == 1'b1, "R10 mirrors", {cv_unipolar, cv_cal}, 5);
    wr(0, 32'd0);
    @(negedge clk);
    chk(cv_unipolar == 2'b00 && cv_cal == 1'b0, "R10 mirrors clear", {cv_unipolar, cv_cal}, 0);

    // R2 / R3 every sequence in one-round at two latencies
    for (int m = 0; m < 4; m++) begin
      one_round(m, 5, 0, 0);
      one_round(m, 2, 0, 3);
    end
    // R3 unused mode codes behave as one-round
    one_round(2, 0, 2, 1);
    one_round(3, 6, 3, 1);

    // R8 reconfiguring write mid-run is ignored
    lat = 3;
    clear_rec();
    wr(0, mk(1, 0, 0, 1, 0, 0));
    repeat (5) @(posedge clk);
    wr(0, mk(1, 1, 7, 2, 3, 1));
    @(negedge clk);
    chk(cv_cal == 1'b0 && cv_unipolar == 2'b00, "R8 outputs frozen", {cv_unipolar, cv_cal}, 0);
    wait_idle("R8 run clear");
    repeat (10) @(negedge clk);
    chk(csr_rdata == 32'h0000_0100, "R8 fields kept", csr_rdata, 32'h100);
    chk(nb == 8, "R8 pass length kept", nb, 8);
    verify(1, 0, "R8");

    // R4 / R5 continuous with stop
    cont_stop(1, 0, 19);
    cont_stop(0, 0, 13);
    cont_stop(3, 5, 6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule